// File: doc/BRIEF.md
# Reference Divider with Port Drive and Test Routing

This block turns a reference clock into a comparison pulse train. A 3-bit ratio code picks the division ratio from eight powers of two. The block also sets the static open-drain output ports, the charge-pump enable and the varactor-drive enable. These follow the control bits and an external pump-disable pin.

In test mode, two of the ports stop showing their programmed levels. Port 0 then carries the half-rate programmable-divider signal and port 1 carries the comparison pulse, so both internal frequencies can be measured off-chip. The test mode must not be combined with the pump-disable pin. If it is, the block raises an error flag and keeps the ports on their programmed levels.

There is no streaming data path here. Every pin is a plain level control or status signal with no handshake, and nothing is held back.

Top module: `refdiv_port_router`

## Requirements
- R1: `ratio_code` value k gives a comparison pulse on `comp_pulse` once every 2^(k+1) reference cycles: 2 for code 0, 256 for code 7.
- R2: Code 3 gives a period of 16 reference cycles, which is 250 kHz from a 4 MHz reference.
- R3: `comp_pulse` is high for exactly one reference cycle per period.
- R4: While `rst_n` is low, `comp_pulse` is 0. After release, the first pulse is visible after the 2^(k+1)-th rising edge.
- R5: With `test_en`=0, `port_sink[i]` equals `port_bits[i]` for every port. A value of 1 means the port sinks current, with its active-low output pulled down.
- R6: With `test_en`=1 and `pump_dis`=0, `port_sink[0]` equals `fpd_half` and `port_sink[1]` equals `comp_pulse`. Ports 2 and 3 still follow their bits.
- R7: `pump_en` is the inverse of `pump_dis`. A value of 0 means the charge pump is in its high-impedance state.
- R8: `drive_en` is the inverse of `drive_off`, whatever the value of `pump_dis`.
- R9: With `test_en`=1 and `pump_dis`=1, `mode_err` is 1 and all ports follow `port_bits`. Otherwise `mode_err` is 0.
- R10: If the code changes to a ratio whose last count is already reached or passed, the next rising edge produces a pulse. The new period starts from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 3 | Division ratio code k, where the ratio is 2^(k+1) |
| test_en | input | 1 | Test mode request |
| drive_off | input | 1 | Turns the varactor drive off |
| pump_dis | input | 1 | External charge-pump disable pin |
| port_bits | input | 4 | Programmed port levels, where 1 means sink |
| fpd_half | input | 1 | Programmable-divider output divided by two |
| comp_pulse | output | 1 | Comparison pulse, one cycle per period |
| port_sink | output | 4 | Port pull-down enables |
| pump_en | output | 1 | Charge-pump enable |
| drive_en | output | 1 | Varactor-drive enable |
| mode_err | output | 1 | Illegal test and pump-disable combination |

## Verification
The port, pump, drive and error outputs are combinational, so they are due in the same cycle as the input change. The bench drives the inputs on the falling edge and checks these outputs one nanosecond later. `comp_pulse` is registered: it appears after the 2^(k+1)-th rising edge following reset release or the last pulse. A code change that lands past the new last count gives a pulse after the very next rising edge. The bench samples `comp_pulse` only at falling edges and counts those edges to measure period, width and first-pulse delay.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_PORTS = 4;

  typedef struct packed {
    logic test_en;
    logic drive_off;
    logic pump_dis;
  } ctrl_t;
endpackage

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output logic              pulse
);
  localparam int CNT_W = 2 ** CODE_W;

  logic [CNT_W-1:0] cnt;
  logic [CODE_W:0]  shamt;
  logic [CNT_W:0]   span;
  logic [CNT_W:0]   last_full;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    shamt     = {1'b0, code} + {{CODE_W{1'b0}}, 1'b1};
    span      = {{CNT_W{1'b0}}, 1'b1} << shamt;
    last_full = span - {{CNT_W{1'b0}}, 1'b1};
    last_cnt  = last_full[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (cnt >= last_cnt) begin
      cnt   <= '0;
      pulse <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
      pulse <= 1'b0;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R3
  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (cnt == '0)); // R10
endmodule

// File: rtl/refdiv_port_mux.sv
module refdiv_port_mux
  import refdiv_pkg::*;
#(
  parameter int PORTS = NUM_PORTS
) (
  input  ctrl_t            ctrl,
  input  logic [PORTS-1:0] bits,
  input  logic             fpd_half,
  input  logic             comp,
  output logic [PORTS-1:0] sink,
  output logic             pump_en,
  output logic             drive_en,
  output logic             err
);
  logic route;

  always_comb begin
    err      = ctrl.test_en & ctrl.pump_dis;
    route    = ctrl.test_en & ~ctrl.pump_dis;
    pump_en  = ~ctrl.pump_dis;
    drive_en = ~ctrl.drive_off;
  end

  assign sink[0] = route ? fpd_half : bits[0];
  assign sink[1] = route ? comp     : bits[1];

  generate
    for (genvar i = 2; i < PORTS; i++) begin : g_static
      assign sink[i] = bits[i];
    end
  endgenerate
endmodule

// File: rtl/refdiv_port_router.sv
module refdiv_port_router
  import refdiv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CODE_W-1:0]    ratio_code,
  input  logic                 test_en,
  input  logic                 drive_off,
  input  logic                 pump_dis,
  input  logic [NUM_PORTS-1:0] port_bits,
  input  logic                 fpd_half,
  output logic                 comp_pulse,
  output logic [NUM_PORTS-1:0] port_sink,
  output logic                 pump_en,
  output logic                 drive_en,
  output logic                 mode_err
);
  ctrl_t ctrl;
  assign ctrl = '{test_en: test_en, drive_off: drive_off, pump_dis: pump_dis};

  refdiv_counter #(.CODE_W(CODE_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (ratio_code),
    .pulse (comp_pulse)
  );

  refdiv_port_mux #(.PORTS(NUM_PORTS)) u_mux (
    .ctrl     (ctrl),
    .bits     (port_bits),
    .fpd_half (fpd_half),
    .comp     (comp_pulse),
    .sink     (port_sink),
    .pump_en  (pump_en),
    .drive_en (drive_en),
    .err      (mode_err)
  );

  AST_NORMAL_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> (port_sink == port_bits)); // R5
  AST_TEST_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && !pump_dis) |-> (port_sink[1] == comp_pulse && port_sink[0] == fpd_half)); // R6
  AST_PUMP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pump_dis |-> !pump_en); // R7
  AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    drive_off |-> !drive_en); // R8
  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && pump_dis) |-> (mode_err && port_sink == port_bits)); // R9
endmodule

// File: tb/refdiv_port_router_test.sv
module refdiv_port_router_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ratio_code = 3'd0;
  logic       test_en = 1'b0, drive_off = 1'b0, pump_dis = 1'b0;
  logic [3:0] port_bits = 4'd0;
  logic       fpd_half = 1'b0;
  logic       comp_pulse, pump_en, drive_en, mode_err;
  logic [3:0] port_sink;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  refdiv_port_router uut (
    .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code), .test_en(test_en),
    .drive_off(drive_off), .pump_dis(pump_dis), .port_bits(port_bits),
    .fpd_half(fpd_half), .comp_pulse(comp_pulse), .port_sink(port_sink),
    .pump_en(pump_en), .drive_en(drive_en), .mode_err(mode_err)
  );

  // {t, os, dis, bits[3:0], fpd, exp_sink[3:0], exp_pe, exp_de, exp_err, p1_routed}
  localparam logic [15:0] VEC [8] = '{
    {1'b0,1'b0,1'b0,4'b1010,1'b1, 4'b1010,1'b1,1'b1,1'b0,1'b0}, // R5
    {1'b0,1'b0,1'b1,4'b0101,1'b0, 4'b0101,1'b0,1'b1,1'b0,1'b0}, // R7
    {1'b0,1'b1,1'b0,4'b1111,1'b1, 4'b1111,1'b1,1'b0,1'b0,1'b0}, // R8
    {1'b0,1'b1,1'b1,4'b0000,1'b1, 4'b0000,1'b0,1'b0,1'b0,1'b0}, // R8 with R7
    {1'b1,1'b0,1'b0,4'b1100,1'b1, 4'b1101,1'b1,1'b1,1'b0,1'b1}, // R6
    {1'b1,1'b0,1'b0,4'b0011,1'b0, 4'b0000,1'b1,1'b1,1'b0,1'b1}, // R6
    {1'b1,1'b0,1'b1,4'b1001,1'b0, 4'b1001,1'b0,1'b1,1'b1,1'b0}, // R9
    {1'b1,1'b1,1'b1,4'b0110,1'b1, 4'b0110,1'b0,1'b0,1'b1,1'b0}  // R9
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // waits for a pulse, then counts falling edges to the next one
  task automatic measure(input string req, input int expect_n);
    int n = 0;
    int guard = 0;
    while (!comp_pulse && guard < 600) begin @(negedge clk); guard++; end
    @(negedge clk);
    check(!comp_pulse, "R3", comp_pulse, 0);
    n = 1;
    while (!comp_pulse && n < 600) begin @(negedge clk); n++; end
    check(n == expect_n, req, n, expect_n);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        finish_run();
      end
    end
  end

  initial begin
    logic [3:0] msk;
    repeat (3) @(negedge clk);
    check(comp_pulse == 1'b0, "R4", comp_pulse, 0);

    // R4: first pulse after the 8th rising edge for code 2
    ratio_code = 3'd2;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (i < 8) check(comp_pulse == 1'b0, "R4", comp_pulse, 0);
      else       check(comp_pulse == 1'b1, "R4", comp_pulse, 1);
    end

    // R1 and R2: periods across the codes
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ratio_code = 3'(k);
      measure("R1", 1 << (k + 1)); // settles the change
      measure((k == 3) ? "R2" : "R1", 1 << (k + 1));
    end

    // control table
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      {test_en, drive_off, pump_dis, port_bits, fpd_half} = VEC[v][15:8];
      #1;
      msk = VEC[v][0] ? 4'b1101 : 4'b1111;
      check((port_sink & msk) == (VEC[v][7:4] & msk),
            VEC[v][0] ? "R6" : (VEC[v][1] ? "R9" : "R5"),
            int'(port_sink & msk), int'(VEC[v][7:4] & msk));
      check({pump_en, drive_en, mode_err} == VEC[v][3:1], "R7 R8 R9",
            int'({pump_en, drive_en, mode_err}), int'(VEC[v][3:1]));
      if (VEC[v][0]) check(port_sink[1] == comp_pulse, "R6", port_sink[1], comp_pulse);
    end

    // R6: port 1 carries the code-0 pulse train, high every other cycle
    begin
      int highs = 0;
      @(negedge clk);
      test_en = 1'b1; pump_dis = 1'b0; port_bits = 4'b0000; ratio_code = 3'd0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        if (port_sink[1]) highs++;
      end
      check(highs == 16, "R6", highs, 16);
      test_en = 1'b0;
    end

    // R10: shorten the ratio after the count has passed the new last value
    @(negedge clk);
    rst_n = 1'b0;
    ratio_code = 3'd7;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(comp_pulse == 1'b0, "R10", comp_pulse, 0);
    ratio_code = 3'd1;
    @(negedge clk);
    check(comp_pulse == 1'b1, "R10", comp_pulse, 1);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check(comp_pulse == (i == 4), "R10", comp_pulse, int'(i == 4));
    end

    finish_run();
  end
endmodule